// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Hazard Control

This block sits in the decode stage of a five-stage in-order pipeline. On every cycle, the execute, memory and write-back stages each present a result entry. An entry carries a valid bit, a destination register number, a register-file class bit (integer or floating point), a load flag and a result value. The block compares the two source operands of the instruction in decode against all valid entries. For each operand it picks where the value comes from: the register file, or one of the three stages. It then drives the selected value out.

When a needed value cannot be ready by the next cycle, the block raises a stall. This happens in two cases. The first is an ordinary operand that is produced by a load still in execute. The second is a branch or register-jump condition that is still being computed in execute, or that is being loaded in memory. The entries carry no state from one cycle to the next: they are refilled from the stage inputs on every cycle. The only register is a wrapping count of forwarded operand values, which advances when an instruction leaves decode.

Top module: `id_bypass_ctl`

## Requirements
- R1: While reset is held, the forwarded-value count `byp_cnt` is zero.
- R2: An operand matches an entry only when all of these hold: the entry is valid, the operand is in use, the register numbers are equal, and the class bits are equal (0 integer, 1 floating point). Operand A is also in use whenever `id_cond_rd` is 1. The select codes are 0 register file, 1 execute, 2 memory, 3 write-back. The operand value output equals the selected entry's value, or the register-file value when the select is 0.
- R3: When several entries match one operand, execute wins over memory, and memory wins over write-back.
- R4: Integer register 0 never matches any entry. Floating-point register 0 matches like any other register.
- R5: A match on a non-load producer in any stage, or on a load in memory or write-back, is forwarded without a stall.
- R6: When the winning match of an operand is a load in execute, `stall` is 1.
- R7: With `id_cond_rd` = 1, the condition is read through operand A. `stall` is 1 when A's winning match is in execute (of any kind) or is a load in memory. A non-load in memory, or any entry in write-back, forwards the condition without a stall.
- R8: Floating-point operands use the same three entries and the same load stall rule as integer operands.
- R9: At each clock edge where `id_vld` = 1 and `stall` = 0, `byp_cnt` rises by the number of operands whose select is not 0. Otherwise it holds. It wraps modulo 2^CNT_W.
- R10: `stall` is 0 whenever `id_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_vld | input | 1 | Decode holds an instruction |
| id_cond_rd | input | 1 | Branch or register jump reading operand A |
| id_src_a | input | REG_W | Operand A register number |
| id_src_a_fp | input | 1 | Operand A is floating point |
| id_src_a_use | input | 1 | Operand A is read |
| id_src_b | input | REG_W | Operand B register number |
| id_src_b_fp | input | 1 | Operand B is floating point |
| id_src_b_use | input | 1 | Operand B is read |
| rf_a_val | input | DATA_W | Register-file value for A |
| rf_b_val | input | DATA_W | Register-file value for B |
| ex_vld | input | 1 | Execute entry valid |
| ex_dst | input | REG_W | Execute destination |
| ex_dst_fp | input | 1 | Execute destination is floating point |
| ex_is_ld | input | 1 | Execute holds a load |
| ex_val | input | DATA_W | Execute result |
| mem_vld | input | 1 | Memory entry valid |
| mem_dst | input | REG_W | Memory destination |
| mem_dst_fp | input | 1 | Memory destination is floating point |
| mem_is_ld | input | 1 | Memory holds a load |
| mem_val | input | DATA_W | Memory result |
| wb_vld | input | 1 | Write-back entry valid |
| wb_dst | input | REG_W | Write-back destination |
| wb_dst_fp | input | 1 | Write-back destination is floating point |
| wb_is_ld | input | 1 | Write-back holds a load |
| wb_val | input | DATA_W | Write-back result |
| fwd_sel_a | output | 2 | Operand A source select |
| fwd_sel_b | output | 2 | Operand B source select |
| opnd_a | output | DATA_W | Operand A value |
| opnd_b | output | DATA_W | Operand B value |
| stall | output | 1 | Hold decode this cycle |
| byp_cnt | output | CNT_W | Forwarded-value count |

## Verification
The bench builds the block with REG_W = 5, DATA_W = 16 and CNT_W = 3. The five-bit register field lets the bench place integer and floating-point register 0 next to ordinary registers. The three-bit count wraps after only a few double-forward cycles, so the modulo behaviour is checked within a short run. The sixteen-bit values keep every stage result and register-file value distinct, so a wrong select shows up directly on the operand outputs.

// File: rtl/id_byp_pkg.sv
`timescale 1ns/1ps
package id_byp_pkg;
    localparam int unsigned N_STG   = 3;
    localparam int unsigned STG_EX  = 0;
    localparam int unsigned STG_MEM = 1;
    localparam int unsigned STG_WB  = 2;

    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2,
        SEL_WB  = 2'd3
    } fwd_sel_e;
endpackage

// File: rtl/byp_operand_sel.sv
`timescale 1ns/1ps
module byp_operand_sel
    import id_byp_pkg::*;
#(
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic [REG_W-1:0]              src,
    input  logic                          src_fp,
    input  logic                          src_use,
    input  logic [DATA_W-1:0]             rf_val,
    input  logic [N_STG-1:0]              ent_vld,
    input  logic [N_STG-1:0][REG_W-1:0]   ent_dst,
    input  logic [N_STG-1:0]              ent_fp,
    input  logic [N_STG-1:0]              ent_ld,
    input  logic [N_STG-1:0][DATA_W-1:0]  ent_val,
    output fwd_sel_e                      sel,
    output logic [DATA_W-1:0]             val,
    output logic                          win_is_ld
);
    logic             int_zero;
    logic [N_STG-1:0] hit;

    assign int_zero = !src_fp && (src == '0);

    // one comparator per published stage entry
    for (genvar g = 0; g < N_STG; g++) begin : g_cmp
        assign hit[g] = ent_vld[g] && src_use && !int_zero
                     && (ent_dst[g] == src) && (ent_fp[g] == src_fp);
    end

    // scan oldest to youngest so the youngest match is the last one written
    always_comb begin
        sel       = SEL_RF;
        val       = rf_val;
        win_is_ld = 1'b0;
        for (int i = N_STG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel       = fwd_sel_e'(2'(i + 1));
                val       = ent_val[i];
                win_is_ld = ent_ld[i];
            end
        end
    end
endmodule

// File: rtl/byp_event_cnt.sv
`timescale 1ns/1ps
module byp_event_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [1:0]       inc_amt,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_en) begin
            st_d.cnt = st_q.cnt + CNT_W'(inc_amt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/id_bypass_ctl.sv
`timescale 1ns/1ps
module id_bypass_ctl
    import id_byp_pkg::*;
#(
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_vld,
    input  logic              id_cond_rd,
    input  logic [REG_W-1:0]  id_src_a,
    input  logic              id_src_a_fp,
    input  logic              id_src_a_use,
    input  logic [REG_W-1:0]  id_src_b,
    input  logic              id_src_b_fp,
    input  logic              id_src_b_use,
    input  logic [DATA_W-1:0] rf_a_val,
    input  logic [DATA_W-1:0] rf_b_val,
    input  logic              ex_vld,
    input  logic [REG_W-1:0]  ex_dst,
    input  logic              ex_dst_fp,
    input  logic              ex_is_ld,
    input  logic [DATA_W-1:0] ex_val,
    input  logic              mem_vld,
    input  logic [REG_W-1:0]  mem_dst,
    input  logic              mem_dst_fp,
    input  logic              mem_is_ld,
    input  logic [DATA_W-1:0] mem_val,
    input  logic              wb_vld,
    input  logic [REG_W-1:0]  wb_dst,
    input  logic              wb_dst_fp,
    input  logic              wb_is_ld,
    input  logic [DATA_W-1:0] wb_val,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic              stall,
    output logic [CNT_W-1:0]  byp_cnt
);
    localparam int unsigned N_OP = 2;

    // stage entries, index 0 = execute (youngest)
    logic [N_STG-1:0]             ent_vld;
    logic [N_STG-1:0][REG_W-1:0]  ent_dst;
    logic [N_STG-1:0]             ent_fp;
    logic [N_STG-1:0]             ent_ld;
    logic [N_STG-1:0][DATA_W-1:0] ent_val;

    assign ent_vld = {wb_vld,    mem_vld,    ex_vld};
    assign ent_dst = {wb_dst,    mem_dst,    ex_dst};
    assign ent_fp  = {wb_dst_fp, mem_dst_fp, ex_dst_fp};
    assign ent_ld  = {wb_is_ld,  mem_is_ld,  ex_is_ld};
    assign ent_val = {wb_val,    mem_val,    ex_val};

    logic [REG_W-1:0]  op_src [N_OP];
    logic              op_fp  [N_OP];
    logic              op_use [N_OP];
    logic [DATA_W-1:0] op_rf  [N_OP];
    fwd_sel_e          op_sel [N_OP];
    logic [DATA_W-1:0] op_val [N_OP];
    logic              op_ld  [N_OP];

    assign op_src[0] = id_src_a;
    assign op_fp[0]  = id_src_a_fp;
    assign op_use[0] = id_src_a_use || id_cond_rd;
    assign op_rf[0]  = rf_a_val;
    assign op_src[1] = id_src_b;
    assign op_fp[1]  = id_src_b_fp;
    assign op_use[1] = id_src_b_use;
    assign op_rf[1]  = rf_b_val;

    for (genvar g = 0; g < N_OP; g++) begin : g_op
        byp_operand_sel #(
            .REG_W  (REG_W),
            .DATA_W (DATA_W)
        ) u_sel (
            .src       (op_src[g]),
            .src_fp    (op_fp[g]),
            .src_use   (op_use[g]),
            .rf_val    (op_rf[g]),
            .ent_vld   (ent_vld),
            .ent_dst   (ent_dst),
            .ent_fp    (ent_fp),
            .ent_ld    (ent_ld),
            .ent_val   (ent_val),
            .sel       (op_sel[g]),
            .val       (op_val[g]),
            .win_is_ld (op_ld[g])
        );
    end

    logic       ld_use_stall;
    logic       cond_stall;
    logic       inc_en;
    logic [1:0] inc_amt;

    always_comb begin
        ld_use_stall = 1'b0;
        for (int k = 0; k < N_OP; k++) begin
            if ((op_sel[k] == SEL_EX) && op_ld[k]) begin
                ld_use_stall = 1'b1;
            end
        end
        // condition must be in hand at the start of the decode cycle
        cond_stall = id_cond_rd
                  && ((op_sel[0] == SEL_EX) || ((op_sel[0] == SEL_MEM) && op_ld[0]));
        stall   = id_vld && (ld_use_stall || cond_stall);
        inc_en  = id_vld && !stall;
        inc_amt = 2'(op_sel[0] != SEL_RF) + 2'(op_sel[1] != SEL_RF);
    end

    byp_event_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (inc_en),
        .inc_amt (inc_amt),
        .cnt     (byp_cnt)
    );

    assign fwd_sel_a = op_sel[0];
    assign fwd_sel_b = op_sel[1];
    assign opnd_a    = op_val[0];
    assign opnd_b    = op_val[1];
endmodule

// File: rtl/id_bypass_ctl_chk.sv
`timescale 1ns/1ps
module id_bypass_ctl_chk #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_vld,
    input logic             id_cond_rd,
    input logic [REG_W-1:0] id_src_a,
    input logic             id_src_a_fp,
    input logic             id_src_a_use,
    input logic             id_src_b_use,
    input logic             ex_vld,
    input logic [REG_W-1:0] ex_dst,
    input logic             ex_dst_fp,
    input logic             ex_is_ld,
    input logic [1:0]       fwd_sel_a,
    input logic [1:0]       fwd_sel_b,
    input logic             stall,
    input logic [CNT_W-1:0] byp_cnt
);
    logic ex_hits_a;
    assign ex_hits_a = ex_vld && (id_src_a_use || id_cond_rd)
                    && (ex_dst == id_src_a) && (ex_dst_fp == id_src_a_fp)
                    && !(!id_src_a_fp && (id_src_a == '0));

    a_r1_cnt_cleared: assert property (@(posedge clk)
        !rst_n |=> byp_cnt == '0);

    a_r2_idle_operand_from_rf: assert property (@(posedge clk) disable iff (!rst_n)
        !id_src_b_use |-> fwd_sel_b == 2'd0);

    a_r3_execute_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ex_hits_a |-> fwd_sel_a == 2'd1);

    a_r4_int_zero_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_src_a_fp && id_src_a == '0) |-> fwd_sel_a == 2'd0);

    a_r6_load_use_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (id_vld && ex_hits_a && ex_is_ld) |-> stall);

    a_r7_cond_in_ex_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (id_vld && id_cond_rd && ex_hits_a) |-> stall);

    a_r9_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || !id_vld) |=> $stable(byp_cnt));

    a_r10_no_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !id_vld |-> !stall);
endmodule

bind id_bypass_ctl id_bypass_ctl_chk #(
    .REG_W (REG_W),
    .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/sim_id_bypass_ctl.sv
`timescale 1ns/1ps
module sim_id_bypass_ctl;
    localparam int RW = 5;
    localparam int DW = 16;
    localparam int CW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic id_vld, id_cond_rd;
    logic [RW-1:0] id_src_a, id_src_b;
    logic id_src_a_fp, id_src_a_use, id_src_b_fp, id_src_b_use;
    logic [DW-1:0] rf_a_val, rf_b_val;
    logic ex_vld, ex_dst_fp, ex_is_ld, mem_vld, mem_dst_fp, mem_is_ld, wb_vld, wb_dst_fp, wb_is_ld;
    logic [RW-1:0] ex_dst, mem_dst, wb_dst;
    logic [DW-1:0] ex_val, mem_val, wb_val;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic [DW-1:0] opnd_a, opnd_b;
    logic stall;
    logic [CW-1:0] byp_cnt;

    id_bypass_ctl #(.REG_W(RW), .DATA_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .id_vld(id_vld), .id_cond_rd(id_cond_rd),
        .id_src_a(id_src_a), .id_src_a_fp(id_src_a_fp), .id_src_a_use(id_src_a_use),
        .id_src_b(id_src_b), .id_src_b_fp(id_src_b_fp), .id_src_b_use(id_src_b_use),
        .rf_a_val(rf_a_val), .rf_b_val(rf_b_val),
        .ex_vld(ex_vld), .ex_dst(ex_dst), .ex_dst_fp(ex_dst_fp), .ex_is_ld(ex_is_ld), .ex_val(ex_val),
        .mem_vld(mem_vld), .mem_dst(mem_dst), .mem_dst_fp(mem_dst_fp), .mem_is_ld(mem_is_ld), .mem_val(mem_val),
        .wb_vld(wb_vld), .wb_dst(wb_dst), .wb_dst_fp(wb_dst_fp), .wb_is_ld(wb_is_ld), .wb_val(wb_val),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .stall(stall), .byp_cnt(byp_cnt)
    );

    typedef struct packed {
        logic [1:0]    sa;
        logic [1:0]    sb;
        logic [DW-1:0] oa;
        logic [DW-1:0] ob;
        logic          st;
        logic [CW-1:0] cnt;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    logic [CW-1:0] exp_cnt;
    bit    done = 1'b0;

    // staged stimulus, index 0 execute, 1 memory, 2 write-back
    logic          s_vld [3];
    logic [RW-1:0] s_dst [3];
    logic          s_fp  [3];
    logic          s_ld  [3];
    logic [DW-1:0] s_val [3];
    logic          s_id_vld, s_cond;
    logic [RW-1:0] s_src [2];
    logic          s_sfp [2];
    logic          s_use [2];
    logic [DW-1:0] s_rf  [2];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_stim();
        for (int i = 0; i < 3; i++) begin
            s_vld[i] = 1'b0; s_dst[i] = '0; s_fp[i] = 1'b0; s_ld[i] = 1'b0;
        end
        s_val[0] = 16'hE001; s_val[1] = 16'hE002; s_val[2] = 16'hE003;
        for (int k = 0; k < 2; k++) begin
            s_src[k] = '0; s_sfp[k] = 1'b0; s_use[k] = 1'b0;
        end
        s_rf[0] = 16'hA1A1; s_rf[1] = 16'hB2B2;
        s_id_vld = 1'b1; s_cond = 1'b0;
    endtask

    task automatic ent(input int i, input int dst, input bit fp, input bit ld);
        s_vld[i] = 1'b1; s_dst[i] = RW'(dst); s_fp[i] = fp; s_ld[i] = ld;
    endtask

    task automatic src(input int k, input int r, input bit fp);
        s_src[k] = RW'(r); s_sfp[k] = fp; s_use[k] = 1'b1;
    endtask

    function automatic int find(input int k);
        bit u;
        u = s_use[k] || (k == 0 && s_cond);
        for (int i = 0; i < 3; i++) begin
            if (s_vld[i] && u && s_dst[i] == s_src[k] && s_fp[i] == s_sfp[k]
                && (s_sfp[k] || s_src[k] != '0))
                return i + 1;
        end
        return 0;
    endfunction

    task automatic drive();
        id_vld = s_id_vld; id_cond_rd = s_cond;
        id_src_a = s_src[0]; id_src_a_fp = s_sfp[0]; id_src_a_use = s_use[0];
        id_src_b = s_src[1]; id_src_b_fp = s_sfp[1]; id_src_b_use = s_use[1];
        rf_a_val = s_rf[0]; rf_b_val = s_rf[1];
        ex_vld = s_vld[0]; ex_dst = s_dst[0]; ex_dst_fp = s_fp[0]; ex_is_ld = s_ld[0]; ex_val = s_val[0];
        mem_vld = s_vld[1]; mem_dst = s_dst[1]; mem_dst_fp = s_fp[1]; mem_is_ld = s_ld[1]; mem_val = s_val[1];
        wb_vld = s_vld[2]; wb_dst = s_dst[2]; wb_dst_fp = s_fp[2]; wb_is_ld = s_ld[2]; wb_val = s_val[2];
    endtask

    // driver: apply one decode cycle and push what the requirements predict
    task automatic issue(input string tag);
        exp_t e;
        int ka, kb;
        bit st;
        @(posedge clk);
        #2;
        drive();
        ka = find(0);
        kb = find(1);
        st = s_id_vld && ((ka == 1 && s_ld[0]) || (kb == 1 && s_ld[0])
             || (s_cond && (ka == 1 || (ka == 2 && s_ld[1]))));
        e.sa  = 2'(ka);
        e.sb  = 2'(kb);
        e.oa  = (ka == 0) ? s_rf[0] : s_val[ka-1];
        e.ob  = (kb == 0) ? s_rf[1] : s_val[kb-1];
        e.st  = st;
        e.cnt = exp_cnt;
        sb_q.push_back(e);
        tag_q.push_back(tag);
        if (s_id_vld && !st)
            exp_cnt = CW'(exp_cnt + CW'(ka != 0) + CW'(kb != 0));
    endtask

    // monitor: compare away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #4;
            if (sb_q.size() > 0) begin
                exp_t e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                chk(fwd_sel_a == e.sa, t, "fwd_sel_a", fwd_sel_a, e.sa);
                chk(fwd_sel_b == e.sb, t, "fwd_sel_b", fwd_sel_b, e.sb);
                chk(opnd_a == e.oa, t, "opnd_a", opnd_a, e.oa);
                chk(opnd_b == e.ob, t, "opnd_b", opnd_b, e.ob);
                chk(stall == e.st, t, "stall", stall, e.st);
                chk(byp_cnt == e.cnt, "R9", "byp_cnt", byp_cnt, e.cnt);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        exp_cnt = '0;
        clear_stim();
        drive();
        repeat (3) @(posedge clk);
        #2;
        chk(byp_cnt == '0, "R1", "byp_cnt in reset", byp_cnt, 0);
        rst_n = 1'b1;

        clear_stim(); src(0, 7, 0); src(1, 9, 0); issue("R2 no entries");
        clear_stim(); ent(0, 7, 0, 0); src(0, 7, 0); issue("R5 execute alu");
        clear_stim(); ent(1, 9, 0, 0); ent(2, 4, 0, 0); src(0, 4, 0); src(1, 9, 0);
        issue("R2 memory and write-back");
        clear_stim(); ent(0, 6, 0, 0); ent(1, 6, 0, 0); ent(2, 6, 0, 0); src(0, 6, 0);
        issue("R3 all three match");
        clear_stim(); ent(1, 6, 0, 0); ent(2, 6, 0, 0); src(1, 6, 0); issue("R3 memory over wb");
        clear_stim(); ent(0, 0, 0, 0); ent(1, 0, 0, 0); src(0, 0, 0); issue("R4 int zero");
        clear_stim(); ent(0, 0, 1, 0); src(0, 0, 1); issue("R4 fp zero");
        clear_stim(); ent(0, 5, 1, 0); src(0, 5, 0); src(1, 5, 1); issue("R8 class compare");
        clear_stim(); ent(0, 8, 0, 1); src(1, 8, 0); issue("R6 load in execute");
        clear_stim(); ent(1, 8, 0, 1); src(1, 8, 0); issue("R5 load in memory");
        clear_stim(); ent(2, 8, 0, 1); src(0, 8, 0); issue("R5 load in wb");
        clear_stim(); ent(0, 8, 0, 1); src(0, 3, 0); issue("R6 unused operand");
        clear_stim(); ent(0, 3, 1, 1); src(0, 3, 1); issue("R8 fp load in execute");
        clear_stim(); ent(2, 3, 1, 1); src(1, 3, 1); issue("R8 fp load in wb");
        clear_stim(); s_cond = 1'b1; s_src[0] = 5'd10; ent(0, 10, 0, 0); issue("R7 cond in execute");
        clear_stim(); s_cond = 1'b1; s_src[0] = 5'd10; ent(1, 10, 0, 1); issue("R7 cond load memory");
        clear_stim(); s_cond = 1'b1; s_src[0] = 5'd10; ent(1, 10, 0, 0); issue("R7 cond alu memory");
        clear_stim(); s_cond = 1'b1; s_src[0] = 5'd10; ent(2, 10, 0, 1); issue("R7 cond load wb");
        clear_stim(); s_id_vld = 1'b0; ent(0, 8, 0, 1); src(0, 8, 0); issue("R10 idle decode");
        for (int n = 0; n < 5; n++) begin
            clear_stim(); ent(0, 12, 0, 0); ent(1, 13, 0, 0); src(0, 12, 0); src(1, 13, 0);
            issue("R9 wrap");
        end
        clear_stim(); s_id_vld = 1'b0; issue("R9 final idle");
        clear_stim(); s_id_vld = 1'b0; issue("R10 drain");
        repeat (2) @(posedge clk);
        #6;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule